// File: doc/BRIEF.md
# Two-Channel PWM Dead-Band Stage with Split Control Buffering

This block sits after the action-qualifier stage of a PWM channel pair. It turns the raw A and B waveforms into the final A and B pin drives. Four steps do the work: source selection for the two delay paths, a rising-edge delay, a falling-edge delay, and polarity inversion of each delayed path. A per-output bypass and a per-output swap then pick which waveform drives each pin. An up-down time base counts from zero to a programmable top and back to zero. It reports a zero event and a top (period) event, and these events time the control reloads.

The control word can be written in two ways. With buffering off, the low six bits go straight into the active copy. With buffering on, those six bits land in a buffer copy and reach the active copy only on a selected time-base event. The two swap bits never go through the buffer. A single write that changes both the swap and the output mode therefore swaps the pins at once, while the mode change waits for the reload event. Every pin drive is registered, so the output lags its input and its active control by one clock.

Top module: `pwm_deadband`

## Requirements
- R1: After reset, both pin outputs are 0, the count is 0, the direction is up, and the active control, buffered control and swap field are all zero.
- R2: The time base goes 0,1,...,P,P-1,...,1,0,1,... for a top value P. `evt_zero` is high while the count is 0, `evt_period` is high while the count equals P, and `tb_dir_down` is high on the falling half.
- R3: With `shadow_en` low, a write puts control bits [5:0] into the active copy at the write edge. The outputs follow one clock later.
- R4: With `shadow_en` high, a write changes only the buffered bits [5:0]. The active copy loads from the buffer at the edge where the selected event is flagged: `load_sel` 0 selects zero, 1 selects period, and 2 or 3 select either event.
- R5: If a write lands on the same edge as a reload, the written value goes into the active copy.
- R6: Swap bits [13:12] take effect at the write edge whatever `shadow_en` is. Bit 12 set drives output A from the B path, and bit 13 set drives output B from the A path.
- R7: Output-mode bit 1 selects the delayed A path over the raw A input, and bit 0 selects the delayed B path over the raw B input. With mode 0 and no swap, each output equals its input one clock earlier.
- R8: The rising-edge path holds low for `red_dly` clocks after its source rises. A delay of 0 passes the source unchanged.
- R9: The falling-edge path stays high for `fed_dly` clocks after its source falls. A delay of 0 passes the source unchanged.
- R10: Input-mode bit 4 feeds the rising path from B instead of A, and bit 5 feeds the falling path from B instead of A. Polarity bit 2 inverts the rising path, and bit 3 inverts the falling path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_period | input | CW | Top value of the up-down count |
| red_dly | input | DW | Rising-edge delay in clocks |
| fed_dly | input | DW | Falling-edge delay in clocks |
| ctl_wr_en | input | 1 | Control write strobe |
| ctl_wr_data | input | 16 | Control write value |
| shadow_en | input | 1 | Route bits [5:0] through the buffer copy |
| load_sel | input | 2 | Reload event select |
| pwm_a_in | input | 1 | Raw A waveform |
| pwm_b_in | input | 1 | Raw B waveform |
| pwm_a_out | output | 1 | Final A drive |
| pwm_b_out | output | 1 | Final B drive |
| tb_count | output | CW | Time-base count |
| tb_dir_down | output | 1 | Count direction, high when falling |
| evt_zero | output | 1 | Count equals zero |
| evt_period | output | 1 | Count equals top |

## Verification
Two cases are hard to reach from the ports. The first is a control write that lands on the exact edge of a reload. The second is a write that changes the swap and the buffered mode in one go, where the outputs must show the swap first and the mode change one half-period later. The stimulus watches `evt_zero` and `evt_period` at the falling clock edge. It raises the write strobe in that same half-cycle, or in a chosen number of cycles before the next event. It then samples the pins just before and just after the reload edge. Fixed A/B levels are picked so that the bypass, the delayed paths and the swapped drives each give a different output pair.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int CTL_W    = 16;
  localparam int LO_W     = 6;
  localparam int SWAP_LSB = 12;

  // Buffered part of the control word, bit 5 down to bit 0
  typedef struct packed {
    logic [1:0] in_sel;    // [5:4] source of falling / rising path
    logic [1:0] pol;       // [3:2] invert falling / rising path
    logic [1:0] out_mode;  // [1:0] use delayed A / delayed B
  } db_lo_t;

  typedef enum logic [1:0] {
    LD_ZERO   = 2'd0,
    LD_PERIOD = 2'd1,
    LD_EITHER = 2'd2,
    LD_EITHR2 = 2'd3
  } load_sel_e;
endpackage

// File: rtl/db_timebase.sv
module db_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] count,
  output logic          dir_down,
  output logic          at_zero,
  output logic          at_period
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      dir_down <= 1'b0;
    end else if (!dir_down) begin
      if (count >= period) begin
        dir_down <= 1'b1;
        count    <= (count == '0) ? '0 : count - ONE;
      end else begin
        count <= count + ONE;
      end
    end else begin
      if (count == '0) begin
        dir_down <= 1'b0;
        count    <= (period == '0) ? '0 : ONE;
      end else begin
        count <= count - ONE;
      end
    end
  end

  assign at_zero   = (count == '0);
  assign at_period = (count == period);
endmodule

// File: rtl/db_ctrl_regs.sv
module db_ctrl_regs
  import db_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             shadow_en,
  input  logic [1:0]       load_sel,
  input  logic             at_zero,
  input  logic             at_period,
  output db_lo_t           act_lo,
  output logic [1:0]       swap
);
  logic [LO_W-1:0] buf_q;
  logic [LO_W-1:0] act_q;
  logic            load_hit;
  logic            unused_hi;

  assign unused_hi = ^{wr_data[CTL_W-1:SWAP_LSB+2], wr_data[SWAP_LSB-1:LO_W]};

  always_comb begin
    case (load_sel_e'(load_sel))
      LD_ZERO:   load_hit = at_zero;
      LD_PERIOD: load_hit = at_period;
      default:   load_hit = at_zero | at_period;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      act_q <= '0;
      swap  <= '0;
    end else begin
      if (wr_en) begin
        swap  <= wr_data[SWAP_LSB +: 2];
        buf_q <= wr_data[LO_W-1:0];
      end
      if (!shadow_en) begin
        if (wr_en) act_q <= wr_data[LO_W-1:0];
      end else if (load_hit) begin
        act_q <= wr_en ? wr_data[LO_W-1:0] : buf_q;
      end
    end
  end

  assign act_lo = db_lo_t'(act_q);
endmodule

// File: rtl/db_edge_delay.sv
module db_edge_delay #(
  parameter int DW     = 8,
  parameter bit RISING = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din,
  input  logic [DW-1:0] dly,
  output logic          dout
);
  // Counts clocks the source has spent at the level whose entry is delayed
  localparam logic [DW-1:0] RUN_RST = RISING ? '0 : '1;
  localparam logic [DW-1:0] RUN_MAX = '1;

  logic [DW-1:0] run_q;
  logic          lvl;
  logic          settled;

  assign lvl     = RISING ? din : ~din;
  assign settled = lvl & (run_q >= dly);

  always_ff @(posedge clk) begin
    if (rst)                 run_q <= RUN_RST;
    else if (!lvl)           run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + DW'(1);
  end

  generate
    if (RISING) begin : g_rise
      assign dout = settled;
    end else begin : g_fall
      assign dout = ~settled;
    end
  endgenerate
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
  import db_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    tb_period,
  input  logic [DW-1:0]    red_dly,
  input  logic [DW-1:0]    fed_dly,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  input  logic             shadow_en,
  input  logic [1:0]       load_sel,
  input  logic             pwm_a_in,
  input  logic             pwm_b_in,
  output logic             pwm_a_out,
  output logic             pwm_b_out,
  output logic [CW-1:0]    tb_count,
  output logic             tb_dir_down,
  output logic             evt_zero,
  output logic             evt_period
);
  db_lo_t     ctl_act;
  logic [1:0] ctl_swap;
  logic       src_r, src_f, dly_r, dly_f, path_a, path_b;

  db_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst(rst), .period(tb_period), .count(tb_count),
    .dir_down(tb_dir_down), .at_zero(evt_zero), .at_period(evt_period)
  );

  db_ctrl_regs u_ctl (
    .clk(clk), .rst(rst), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
    .shadow_en(shadow_en), .load_sel(load_sel), .at_zero(evt_zero),
    .at_period(evt_period), .act_lo(ctl_act), .swap(ctl_swap)
  );

  assign src_r = ctl_act.in_sel[0] ? pwm_b_in : pwm_a_in;
  assign src_f = ctl_act.in_sel[1] ? pwm_b_in : pwm_a_in;

  db_edge_delay #(.DW(DW), .RISING(1'b1)) u_red (
    .clk(clk), .rst(rst), .din(src_r), .dly(red_dly), .dout(dly_r)
  );
  db_edge_delay #(.DW(DW), .RISING(1'b0)) u_fed (
    .clk(clk), .rst(rst), .din(src_f), .dly(fed_dly), .dout(dly_f)
  );

  assign path_a = ctl_act.out_mode[1] ? (dly_r ^ ctl_act.pol[0]) : pwm_a_in;
  assign path_b = ctl_act.out_mode[0] ? (dly_f ^ ctl_act.pol[1]) : pwm_b_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_a_out <= 1'b0;
      pwm_b_out <= 1'b0;
    end else begin
      pwm_a_out <= ctl_swap[0] ? path_b : path_a;
      pwm_b_out <= ctl_swap[1] ? path_a : path_b;
    end
  end
endmodule

// File: rtl/db_deadband_chk.sv
module db_deadband_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [15:0]   wr_data,
  input logic          shadow_en,
  input logic [1:0]    load_sel,
  input logic          at_zero,
  input logic          at_period,
  input logic [5:0]    act_bits,
  input logic [1:0]    swap,
  input logic          a_in,
  input logic          a_out,
  input logic [CW-1:0] count,
  input logic [CW-1:0] period,
  input logic          dir_down
);
  logic hit;
  logic unused_chk;
  assign unused_chk = ^{wr_data[15:14], wr_data[11:6]};
  assign hit = (load_sel == 2'd0) ? at_zero :
               (load_sel == 2'd1) ? at_period : (at_zero | at_period);

  // R2
  a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
    (!dir_down && count < period) |=> count == $past(count) + 1'b1);
  // R3
  a_r3_direct_write: assert property (@(posedge clk) disable iff (rst)
    (!shadow_en && wr_en) |=> act_bits == $past(wr_data[5:0]));
  // R4
  a_r4_hold_between_events: assert property (@(posedge clk) disable iff (rst)
    (shadow_en && !hit) |=> $stable(act_bits));
  // R5
  a_r5_write_on_reload: assert property (@(posedge clk) disable iff (rst)
    (shadow_en && hit && wr_en) |=> act_bits == $past(wr_data[5:0]));
  // R6
  a_r6_swap_immediate: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> swap == $past(wr_data[13:12]));
  // R7
  a_r7_bypass_a: assert property (@(posedge clk) disable iff (rst)
    (act_bits[1:0] == 2'b00 && swap == 2'b00) |=> a_out == $past(a_in));
endmodule

bind pwm_deadband db_deadband_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
  .shadow_en(shadow_en), .load_sel(load_sel), .at_zero(evt_zero),
  .at_period(evt_period), .act_bits(ctl_act), .swap(ctl_swap),
  .a_in(pwm_a_in), .a_out(pwm_a_out), .count(tb_count),
  .period(tb_period), .dir_down(tb_dir_down)
);

// File: tb/tb_pwm_deadband.sv
module tb_pwm_deadband;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int DW = 8;
  localparam int P  = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [CW-1:0] tb_period = CW'(P);
  logic [DW-1:0] red_dly = '0, fed_dly = '0;
  logic ctl_wr_en = 1'b0;
  logic [15:0] ctl_wr_data = '0;
  logic shadow_en = 1'b0;
  logic [1:0] load_sel = 2'd0;
  logic pwm_a_in = 1'b0, pwm_b_in = 1'b0;
  logic pwm_a_out, pwm_b_out, tb_dir_down, evt_zero, evt_period;
  logic [CW-1:0] tb_count;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_deadband #(.CW(CW), .DW(DW)) dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(logic [15:0] d);
    ctl_wr_data = d; ctl_wr_en = 1'b1;
    @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  task automatic wait_zero();
    @(negedge clk);
    while (!evt_zero) @(negedge clk);
  endtask

  task automatic wait_period();
    @(negedge clk);
    while (!evt_period) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 count", tb_count, 0);
    chk("R1 dir", tb_dir_down, 0);
    chk("R1 a_out", pwm_a_out, 0);
    chk("R1 b_out", pwm_b_out, 0);
  endtask

  task automatic t_counter();
    int exp_c = 0;
    bit dn = 1'b1;
    wait_zero();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!dn) begin
        if (exp_c == P) begin dn = 1'b1; exp_c = P - 1; end
        else exp_c++;
      end else begin
        if (exp_c == 0) begin dn = 1'b0; exp_c = 1; end
        else exp_c--;
      end
      chk("R2 count", tb_count, exp_c);
      chk("R2 dir", tb_dir_down, dn);
      chk("R2 evt_zero", evt_zero, exp_c == 0);
      chk("R2 evt_period", evt_period, exp_c == P);
    end
  endtask

  task automatic t_bypass_direct();
    shadow_en = 1'b0;
    for (int p = 0; p < 4; p++) begin
      pwm_a_in = p[1]; pwm_b_in = p[0];
      tick(1);
      chk("R7 a bypass", pwm_a_out, p[1]);
      chk("R7 b bypass", pwm_b_out, p[0]);
    end
    pwm_a_in = 1'b1; pwm_b_in = 1'b1;
    ctl_write(16'h0029);
    tick(1);
    chk("R3 a raw", pwm_a_out, 1);
    chk("R3 b inverted", pwm_b_out, 0);
  endtask

  task automatic t_input_mode();
    pwm_a_in = 1'b1; pwm_b_in = 1'b0;
    ctl_write(16'h0013);
    tick(1);
    chk("R10 rise from B", pwm_a_out, 0);
    chk("R10 fall from A", pwm_b_out, 1);
    ctl_write(16'h002B);
    tick(1);
    chk("R10 rise from A", pwm_a_out, 1);
    chk("R10 fall B inverted", pwm_b_out, 1);
  endtask

  task automatic t_rising();
    red_dly = 8'd3; fed_dly = '0;
    ctl_write(16'h0003);
    pwm_a_in = 1'b0; pwm_b_in = 1'b0;
    tick(4);
    pwm_a_in = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk("R8 rising delay", pwm_a_out, k >= 4);
      chk("R9 zero fall delay", pwm_b_out, 1);
    end
  endtask

  task automatic t_falling();
    red_dly = '0; fed_dly = 8'd2;
    pwm_a_in = 1'b1;
    tick(4);
    pwm_a_in = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk("R9 falling delay", pwm_b_out, k <= 2);
      chk("R8 zero rise delay", pwm_a_out, 0);
    end
    fed_dly = '0;
  endtask

  task automatic t_shadow();
    ctl_write(16'h0000);
    pwm_a_in = 1'b1; pwm_b_in = 1'b0;
    shadow_en = 1'b1; load_sel = 2'd1;
    wait_zero();
    ctl_write(16'h002B);
    tick(1);
    chk("R4 held before period", pwm_b_out, 0);
    wait_period();
    tick(2);
    chk("R4 loaded at period", pwm_b_out, 1);
    load_sel = 2'd0;
    ctl_write(16'h0000);
    wait_zero();
    chk("R4 held until zero", pwm_b_out, 1);
    tick(2);
    chk("R4 loaded at zero", pwm_b_out, 0);
    load_sel = 2'd2;
    ctl_write(16'h002B);
    wait_period();
    tick(2);
    chk("R4 either event", pwm_b_out, 1);
  endtask

  task automatic t_same_cycle();
    load_sel = 2'd0;
    ctl_write(16'h0013);
    wait_zero();
    ctl_write(16'h0000);
    tick(1);
    chk("R5 a", pwm_a_out, 1);
    chk("R5 b", pwm_b_out, 0);
  endtask

  task automatic t_swap();
    pwm_a_in = 1'b1; pwm_b_in = 1'b0;
    ctl_write(16'h302B);
    tick(1);
    chk("R6 swap now a", pwm_a_out, 0);
    chk("R6 swap now b", pwm_b_out, 1);
    wait_zero();
    tick(2);
    chk("R6 mode later a", pwm_a_out, 1);
    chk("R6 mode later b", pwm_b_out, 1);
    pwm_b_in = 1'b1;
    tick(1);
    chk("R6 swapped a", pwm_a_out, 0);
    ctl_write(16'h002B);
    tick(1);
    chk("R6 unswap a", pwm_a_out, 1);
    chk("R6 unswap b", pwm_b_out, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    t_reset();
    t_counter();
    t_bypass_direct();
    t_input_mode();
    t_rising();
    t_falling();
    t_shadow();
    t_same_cycle();
    t_swap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule